// File: doc/BRIEF.md
# System-Monitor Watchdog Timer

This block watches a processor for loss of control. Once software has started it, a free-running counter counts clock cycles. When the selected interval elapses, the block sets a sticky interrupt flag. That flag drives an interrupt request, which an enable input gates. If the reset enable is set, a second stage follows. A fixed delay after the interrupt flag sets, the block drives a short system reset request and records that the watchdog caused the reset. Software keeps the system alive by writing the restart command often enough. Writing that command clears the counter and also cancels any pending reset stage.

A byte-wide register port reaches two locations. The control/status register holds the cause flags, the reset enable and the restart command. A second location holds the two-bit interval select. A power-on reset stops the timer, sets the power-on flag and clears every other state bit. The timer stays stopped until the first restart command. An external reset keeps the timer running from zero and keeps the power-on and watchdog-reset flags. It clears the interval select, the reset enable and the interrupt flag.

Top module: `wdt_monitor`

## Requirements
- R1: After power-on reset, the control register (address 0) reads 0x40, the interval register (address 1) reads 0x00, and both `irq` and `rst_req` are low.
- R2: Interval select value s (address 1, bits 1:0) sets the interrupt flag (control bit 3) exactly 2^(E-EXP_SHIFT) clocks after the restart write, where E is 23, 25, 26 and 28 for s = 0, 1, 2 and 3.
- R3: After power-on reset the timer does not count, and no time-out occurs, until software writes 1 to control bit 0.
- R4: Writing 1 to control bit 0 clears the counter in that cycle, so the next time-out moves to a full interval after the latest restart. Bit 0 always reads back as 0.
- R5: `irq` is high exactly when the interrupt flag is set and `irq_en` is high.
- R6: Only a time-out sets the interrupt flag, and it stays set. A control write with bit 3 = 0 clears it, and a write with bit 3 = 1 leaves it unchanged.
- R7: With the reset enable (control bit 1) set, `rst_req` rises RST_DELAY clocks after the interrupt flag sets and stays high for RST_PULSE clocks. In that cycle it sets the reset flag (control bit 2) and clears the counter, and the timer keeps running.
- R8: With the reset enable clear, `rst_req` never asserts and the reset flag is never set.
- R9: A restart write while the reset stage is pending cancels that reset request.
- R10: The power-on flag (control bit 6) is set by power-on reset and follows the value written to bit 6.
- R11: While `ext_rst` is high, register writes are ignored. It clears the interrupt flag, the reset enable and the interval select, and it restarts the counter from zero. It leaves the power-on flag, the reset flag and the running state unchanged.
- R12: Power-on reset clears the reset flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on / power-fail reset, active low, asynchronous |
| ext_rst | input | 1 | External reset, active high, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control/status, 1 interval select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected address |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench runs all four interval selects from a fresh restart. It samples the flag one cycle before and at the expected edge, which catches a wrong exponent and any off-by-one in the terminal count. A second restart issued mid-interval tells a counter that restarts apart from one that only sets a flag. A restart issued while the reset stage is pending tells a cancelled stage apart from one that still fires at the original time. Runs with the reset enable on and off, followed by an external reset and a power-on reset, tell apart which flags each kind of reset keeps and which it clears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int DATA_W      = 8;
   localparam int SEL_W       = 2;
   localparam int MAX_BASE    = 28;

   // control/status register bit positions (software-visible encoding)
   localparam int BIT_POR     = 6;
   localparam int BIT_INT     = 3;
   localparam int BIT_RSTF    = 2;
   localparam int BIT_RST_EN  = 1;
   localparam int BIT_RESTART = 0;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_SEL  = 1'b1;

   // unscaled interval exponent for each select code
   function automatic int base_exp(input int code);
      case (code)
         0:       base_exp = 23;
         1:       base_exp = 25;
         2:       base_exp = 26;
         default: base_exp = MAX_BASE;
      endcase
   endfunction
endpackage

// File: rtl/wdt_interval.sv
module wdt_interval #(
   parameter int EXP_SHIFT = 0
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     clr,
   input  logic                     run,
   input  logic [wdt_pkg::SEL_W-1:0] sel,
   output logic                     timeout
);
   localparam int CW    = wdt_pkg::MAX_BASE - EXP_SHIFT;
   localparam int NSEL  = 1 << wdt_pkg::SEL_W;

   logic [CW-1:0]   cnt_q;
   logic [NSEL-1:0] hit;

   for (genvar i = 0; i < NSEL; i++) begin : g_term
      localparam int EI = wdt_pkg::base_exp(i) - EXP_SHIFT;
      localparam logic [CW-1:0] TERM = {CW{1'b1}} >> (CW - EI);
      assign hit[i] = (cnt_q == TERM);
   end

   assign timeout = run && !clr && hit[sel];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (run) begin
         if (timeout)   cnt_q <= '0;
         else           cnt_q <= cnt_q + 1'b1;
      end
   end

   // stopped timer holds zero
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
      !run |-> (cnt_q == '0));
   // restart or clear leaves the counter at zero
   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
   parameter int RST_DELAY = 512,
   parameter int RST_PULSE = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic timeout,
   input  logic cancel,
   input  logic rst_en,
   output logic fire,
   output logic rst_req
);
   localparam int DW = $clog2(RST_DELAY);
   localparam int PW = $clog2(RST_PULSE + 1);

   logic          pend_q;
   logic [DW-1:0] dly_q;
   logic [PW-1:0] pcnt_q;
   logic          dly_last;

   assign dly_last = (dly_q == DW'(RST_DELAY - 1));
   assign fire     = pend_q && dly_last && rst_en && !cancel;
   assign rst_req  = (pcnt_q != '0);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pend_q <= 1'b0;
         dly_q  <= '0;
      end else if (cancel) begin
         pend_q <= 1'b0;
         dly_q  <= '0;
      end else if (pend_q) begin
         if (dly_last) pend_q <= 1'b0;
         else          dly_q  <= dly_q + 1'b1;
      end else if (timeout) begin
         pend_q <= 1'b1;
         dly_q  <= '0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              pcnt_q <= '0;
      else if (fire)           pcnt_q <= PW'(RST_PULSE);
      else if (pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
   end

   assert_fire_req_R7: assert property (@(posedge clk) disable iff (!por_n)
      fire |=> rst_req);
   assert_fire_gate_R8: assert property (@(posedge clk) disable iff (!por_n)
      fire |-> rst_en);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
(
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              timeout,
   input  logic              fire,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              int_flag,
   output logic              rst_en,
   output logic [SEL_W-1:0]  sel,
   output logic              run,
   output logic              restart
);
   logic por_flag, rst_flag;
   logic ctl_wr, sel_wr;
   logic unused_wbits;

   assign ctl_wr       = reg_wr && !ext_rst && (reg_addr == ADDR_CTRL);
   assign sel_wr       = reg_wr && !ext_rst && (reg_addr == ADDR_SEL);
   assign restart      = ctl_wr && reg_wdata[BIT_RESTART];
   assign unused_wbits = ^{reg_wdata[7], reg_wdata[5:4]};

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         por_flag <= 1'b1;
         int_flag <= 1'b0;
         rst_flag <= 1'b0;
         rst_en   <= 1'b0;
         sel      <= '0;
         run      <= 1'b0;
      end else begin
         if (ext_rst) begin
            int_flag <= 1'b0;
            rst_en   <= 1'b0;
            sel      <= '0;
         end else begin
            if (timeout)                          int_flag <= 1'b1;
            else if (ctl_wr && !reg_wdata[BIT_INT]) int_flag <= 1'b0;
            if (ctl_wr) begin
               rst_en   <= reg_wdata[BIT_RST_EN];
               por_flag <= reg_wdata[BIT_POR];
            end
            if (sel_wr)  sel <= reg_wdata[SEL_W-1:0];
            if (restart) run <= 1'b1;
         end
         if (fire)                                rst_flag <= 1'b1;
         else if (ctl_wr && !reg_wdata[BIT_RSTF]) rst_flag <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CTRL) begin
         reg_rdata[BIT_POR]    = por_flag;
         reg_rdata[BIT_INT]    = int_flag;
         reg_rdata[BIT_RSTF]   = rst_flag;
         reg_rdata[BIT_RST_EN] = rst_en;
      end else begin
         reg_rdata[SEL_W-1:0]  = sel;
      end
   end

   assert_int_source_R6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(int_flag) |-> $past(timeout));
   assert_rstflag_gate_R8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_flag) |-> $past(rst_en));
endmodule

// File: rtl/wdt_monitor.sv
module wdt_monitor #(
   parameter int EXP_SHIFT = 0,
   parameter int RST_DELAY = 512,
   parameter int RST_PULSE = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       ext_rst,
   input  logic       reg_wr,
   input  logic       reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       irq_en,
   output logic       irq,
   output logic       rst_req
);
   if (EXP_SHIFT < 0 || EXP_SHIFT > 22) begin : g_bad_shift
      $error("EXP_SHIFT must lie in 0..22");
   end
   if (RST_DELAY < 2) begin : g_bad_delay
      $error("RST_DELAY must be at least 2");
   end
   if (RST_PULSE < 1) begin : g_bad_pulse
      $error("RST_PULSE must be at least 1");
   end

   logic                      timeout, fire, restart, cancel, clr;
   logic                      int_flag, rst_en, run;
   logic [wdt_pkg::SEL_W-1:0] sel;

   assign cancel = restart || ext_rst;
   assign clr    = cancel || fire;
   assign irq    = int_flag && irq_en;

   wdt_regs u_regs (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .timeout(timeout), .fire(fire), .reg_rdata(reg_rdata),
      .int_flag(int_flag), .rst_en(rst_en), .sel(sel),
      .run(run), .restart(restart)
   );

   wdt_interval #(.EXP_SHIFT(EXP_SHIFT)) u_interval (
      .clk(clk), .por_n(por_n), .clr(clr), .run(run),
      .sel(sel), .timeout(timeout)
   );

   wdt_stage #(.RST_DELAY(RST_DELAY), .RST_PULSE(RST_PULSE)) u_stage (
      .clk(clk), .por_n(por_n), .timeout(timeout), .cancel(cancel),
      .rst_en(rst_en), .fire(fire), .rst_req(rst_req)
   );
endmodule

// File: tb/wdt_monitor_test.sv
module wdt_monitor_test;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_rst = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_en = 1'b0;
   logic       irq, rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdt_monitor #(.EXP_SHIFT(20), .RST_DELAY(512), .RST_PULSE(2)) uut (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_en(irq_en), .irq(irq), .rst_req(rst_req)
   );

   function automatic int limit_of(input int s);
      case (s)
         0: limit_of = 8;
         1: limit_of = 32;
         2: limit_of = 64;
         default: limit_of = 256;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic do_por();
      por_n = 1'b0;
      tick(2);
      por_n = 1'b1;
      tick(1);
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      rd_reg(1'b0, d); check("R1 ctrl", d, 8'h40);
      rd_reg(1'b1, d); check("R1 sel", d, 8'h00);
      check("R1 irq", irq, 0);
      check("R1 rst_req", rst_req, 0);
      irq_en = 1'b1;
      tick(300);
      rd_reg(1'b0, d); check("R3 idle after power-on", d, 8'h40);
      check("R3 irq idle", irq, 0);
      irq_en = 1'b0;
   endtask

   task automatic t_por_flag();
      logic [7:0] d;
      wr_reg(1'b0, 8'h00); rd_reg(1'b0, d); check("R10 por flag cleared", d, 8'h00);
      wr_reg(1'b0, 8'h40); rd_reg(1'b0, d); check("R10 por flag written", d, 8'h40);
   endtask

   task automatic t_intervals();
      logic [7:0] d;
      for (int s = 0; s < 4; s++) begin
         wr_reg(1'b1, 8'(s));
         wr_reg(1'b0, 8'h41);
         rd_reg(1'b0, d); check("R4 restart reads 0", d, 8'h40);
         tick(limit_of(s) - 1);
         rd_reg(1'b0, d); check("R2 before interval", d[3], 0);
         tick(1);
         rd_reg(1'b0, d); check("R2 at interval", d[3], 1);
      end
   endtask

   task automatic t_irq_and_flag();
      logic [7:0] d;
      irq_en = 1'b0; #1; check("R5 irq masked", irq, 0);
      irq_en = 1'b1; #1; check("R5 irq enabled", irq, 1);
      tick(20);
      rd_reg(1'b0, d); check("R6 flag sticky", d[3], 1);
      wr_reg(1'b0, 8'h48);
      rd_reg(1'b0, d); check("R6 write 1 keeps", d[3], 1);
      wr_reg(1'b0, 8'h40);
      rd_reg(1'b0, d); check("R6 write 0 clears", d[3], 0);
      check("R5 irq after clear", irq, 0);
      wr_reg(1'b0, 8'h48);
      rd_reg(1'b0, d); check("R6 write 1 does not set", d[3], 0);
      irq_en = 1'b0;
   endtask

   task automatic t_postpone();
      logic [7:0] d;
      wr_reg(1'b1, 8'h00);
      wr_reg(1'b0, 8'h41);
      tick(4);
      wr_reg(1'b0, 8'h41);
      tick(7);
      rd_reg(1'b0, d); check("R4 postponed, not yet", d[3], 0);
      tick(1);
      rd_reg(1'b0, d); check("R4 postponed time-out", d[3], 1);
   endtask

   task automatic t_no_reset_enable();
      logic [7:0] d;
      int seen = 0;
      wr_reg(1'b1, 8'h00);
      wr_reg(1'b0, 8'h41);
      for (int i = 0; i < 700; i++) begin
         tick(1);
         if (rst_req) seen++;
      end
      check("R8 no rst_req when disabled", seen, 0);
      rd_reg(1'b0, d); check("R8 reset flag stays clear", d, 8'h48);
   endtask

   task automatic t_reset_stage();
      logic [7:0] d;
      wr_reg(1'b1, 8'h03);
      wr_reg(1'b0, 8'h43);
      tick(256);
      rd_reg(1'b0, d); check("R7 interrupt first", d[3], 1);
      tick(511);
      check("R7 no request before delay", rst_req, 0);
      tick(1);
      check("R7 request after delay", rst_req, 1);
      rd_reg(1'b0, d); check("R7 reset flag set", d, 8'h4E);
      tick(1);
      check("R7 request second cycle", rst_req, 1);
      tick(1);
      check("R7 request ends", rst_req, 0);
      wr_reg(1'b0, 8'h46);
      rd_reg(1'b0, d); check("R7 flags after clear", d, 8'h46);
      tick(252);
      rd_reg(1'b0, d); check("R7 timer restarted, not yet", d[3], 0);
      tick(1);
      rd_reg(1'b0, d); check("R7 timer kept running", d[3], 1);
   endtask

   task automatic t_cancel();
      int seen = 0;
      wr_reg(1'b0, 8'h4F);
      tick(356);
      wr_reg(1'b0, 8'h4F);
      for (int i = 0; i < 767; i++) begin
         tick(1);
         if (rst_req) seen++;
      end
      check("R9 pending request cancelled", seen, 0);
      tick(1);
      check("R9 later request still works", rst_req, 1);
      tick(2);
   endtask

   task automatic t_ext_reset();
      logic [7:0] d;
      ext_rst = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h02;
      @(negedge clk);
      ext_rst = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
      rd_reg(1'b0, d); check("R11 ctrl after ext reset", d, 8'h44);
      rd_reg(1'b1, d); check("R11 sel cleared, write ignored", d, 8'h00);
      tick(7);
      rd_reg(1'b0, d); check("R11 timer runs from zero, not yet", d[3], 0);
      tick(1);
      rd_reg(1'b0, d); check("R11 timer still running", d[3], 1);
   endtask

   task automatic t_power_fail();
      logic [7:0] d;
      do_por();
      rd_reg(1'b0, d); check("R12 reset flag cleared by power-on", d, 8'h40);
      tick(300);
      rd_reg(1'b0, d); check("R3 disabled after power-on", d, 8'h40);
      check("R12 no request", rst_req, 0);
   endtask

   initial begin
      tick(3);
      por_n = 1'b1;
      tick(1);
      t_reset_state();
      t_por_flag();
      t_intervals();
      t_irq_and_flag();
      t_postpone();
      t_no_reset_enable();
      t_reset_stage();
      t_cancel();
      t_ext_reset();
      t_power_fail();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule